// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block carries out the three arithmetic and logic instructions of a small 16-bit machine with eight general registers: two's-complement addition, bitwise AND and bitwise complement. It decodes a 16-bit instruction word. It tells the surrounding register file which two registers to read. It takes the two values that come back and returns, in the same cycle, the result word, the destination register index and a write enable.

The block also owns the three-bit sign condition register. Every result the block writes sets exactly one of three flags: negative, zero or positive. Load data arriving from memory sets the flags the same way when it is flagged by its own strobe. Branch logic elsewhere reads the flags. Fetch, the register file and memory sit outside the block.

Top module: `alu_nzp_unit`

## Requirements
- R1: Opcode 0001 in bits 15:12 with bit 5 clear gives res_data = src_a + src_b, wrapped to 16 bits, with no carry or overflow output.
- R2: For opcode 0001 or 0101 with bit 5 set, the second operand is bits 4:0 sign-extended to 16 bits (bit 4 copied into bits 15:5), and src_b has no effect.
- R3: Opcode 0101 with bit 5 clear gives res_data = src_a & src_b.
- R4: Opcode 1001 gives res_data = ~src_a whatever bits 5:0 hold.
- R5: In register mode (bit 5 clear) of 0001 and 0101, bits 4:3 have no effect on the result.
- R6: res_we is 1 in the same cycle as op_valid when the opcode is 0001, 0101 or 1001. res_dst equals bits 11:9. rd_idx_a equals bits 8:6 and rd_idx_b equals bits 2:0.
- R7: Any other opcode, or op_valid low, gives res_we = 0 and leaves the condition register unchanged.
- R8: At the clock edge where res_we is 1, cc (bit 2 N, bit 1 Z, bit 0 P) becomes 100 if res_data bit 15 is set, 010 if res_data is zero, and 001 otherwise.
- R9: At an edge where ld_valid is 1 and res_we is 0, cc is set from ld_data by the same rule. When both are high, the operate result takes priority.
- R10: A synchronous active-high reset sets cc to 010. At any edge with neither update, cc holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | Value of the register named by rd_idx_a |
| src_b | input | 16 | Value of the register named by rd_idx_b |
| ld_valid | input | 1 | Load data is valid and updates the flags |
| ld_data | input | 16 | Value loaded from memory |
| rd_idx_a | output | 3 | Index of the first source register |
| rd_idx_b | output | 3 | Index of the second source register |
| res_data | output | 16 | Result word |
| res_dst | output | 3 | Destination register index |
| res_we | output | 1 | Register write enable |
| cc | output | 3 | Condition flags {N,Z,P}, one-hot |

## Verification
The bench sweeps all sixteen opcode values against operand pairs that include zero, one, the largest positive value, the most negative value and all-ones, plus words from a shift-register sequence. These operands separate wraparound, sign-boundary and zero results, and they expose any mix-up between the operations. Every one of the 32 immediate values is tried in both the add and the and form. Register-mode instructions carry nonzero junk in bits 4:3, and complement instructions carry junk in bits 5:0, so a decoder that wrongly looks at those fields shows up. Load strobes are issued alone, together with an operate write, and together with an illegal opcode, so the priority rule and the hold rule can each be seen in the flags.

// File: rtl/opu_pkg.sv
package opu_pkg;

    localparam int DATA_W = 16;
    localparam int IMM_W  = 5;
    localparam int RIDX_W = 3;
    localparam int OPC_W  = 4;
    localparam int CC_W   = 3;

    localparam int OPC_LSB  = DATA_W - OPC_W;
    localparam int DST_LSB  = OPC_LSB - RIDX_W;
    localparam int SRCA_LSB = DST_LSB - RIDX_W;
    localparam int MODE_BIT = IMM_W;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_ADD  = 2'd1,
        K_AND  = 2'd2,
        K_NOT  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic                use_imm;
        logic [RIDX_W-1:0]   dst;
        logic [RIDX_W-1:0]   src_a_idx;
        logic [RIDX_W-1:0]   src_b_idx;
        logic [DATA_W-1:0]   imm;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } nzp_t;

    localparam nzp_t NZP_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] f);
        return {{(DATA_W-IMM_W){f[IMM_W-1]}}, f};
    endfunction

    function automatic nzp_t classify(input logic [DATA_W-1:0] v);
        nzp_t r;
        r.n = v[DATA_W-1];
        r.z = (v == '0);
        r.p = !v[DATA_W-1] && (v != '0);
        return r;
    endfunction

endpackage

// File: rtl/opu_decode.sv
module opu_decode
    import opu_pkg::*;
(
    input  logic              valid,
    input  logic [DATA_W-1:0] word,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc           = word[DATA_W-1:OPC_LSB];
        dec.dst       = word[OPC_LSB-1:DST_LSB];
        dec.src_a_idx = word[DST_LSB-1:SRCA_LSB];
        dec.src_b_idx = word[RIDX_W-1:0];
        dec.use_imm   = word[MODE_BIT];
        dec.imm       = sext_imm(word[IMM_W-1:0]);
        dec.kind      = K_NONE;
        if (valid) begin
            unique case (opc)
                OPC_ADD: dec.kind = K_ADD;
                OPC_AND: dec.kind = K_AND;
                OPC_NOT: dec.kind = K_NOT;
                default: dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              we
);
    logic [DATA_W-1:0] opnd_b;

    always_comb begin
        opnd_b = dec.use_imm ? dec.imm : b;
        unique case (dec.kind)
            K_ADD:   y = a + opnd_b;
            K_AND:   y = a & opnd_b;
            K_NOT:   y = ~a;
            default: y = '0;
        endcase
        we = (dec.kind != K_NONE);
    end
endmodule

// File: rtl/opu_ccreg.sv
module opu_ccreg
    import opu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output nzp_t              flags
);
    nzp_t nxt;

    always_comb begin
        nxt = flags;
        if (wr_valid)
            nxt = classify(wr_data);
        else if (ld_valid)
            nxt = classify(ld_data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= NZP_RESET;
        else
            flags <= nxt;
    end
endmodule

// File: rtl/alu_nzp_unit.sv
module alu_nzp_unit
    import opu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output logic [RIDX_W-1:0] rd_idx_a,
    output logic [RIDX_W-1:0] rd_idx_b,
    output logic [DATA_W-1:0] res_data,
    output logic [RIDX_W-1:0] res_dst,
    output logic              res_we,
    output logic [CC_W-1:0]   cc
);
    dec_t dec;
    nzp_t flags;

    opu_decode u_dec (
        .valid (op_valid),
        .word  (instr),
        .dec   (dec)
    );

    opu_alu u_alu (
        .dec (dec),
        .a   (src_a),
        .b   (src_b),
        .y   (res_data),
        .we  (res_we)
    );

    opu_ccreg u_cc (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (res_we),
        .wr_data  (res_data),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .flags    (flags)
    );

    assign rd_idx_a = dec.src_a_idx;
    assign rd_idx_b = dec.src_b_idx;
    assign res_dst  = dec.dst;
    assign cc       = {flags.n, flags.z, flags.p};
endmodule

// File: rtl/opu_checker.sv
module opu_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [15:0] instr,
    input logic [15:0] src_a,
    input logic [15:0] src_b,
    input logic        ld_valid,
    input logic [15:0] ld_data,
    input logic [15:0] res_data,
    input logic        res_we,
    input logic [2:0]  cc
);
    logic legal;
    assign legal = op_valid && (instr[15:12] == 4'b0001 || instr[15:12] == 4'b0101 ||
                                instr[15:12] == 4'b1001);

    AST_WE_ONLY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        res_we == legal); // R7

    AST_NOT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        (res_we && instr[15:12] == 4'b1001) |-> res_data == ~src_a); // R4

    AST_AND_REG: assert property (@(posedge clk) disable iff (rst)
        (res_we && instr[15:12] == 4'b0101 && !instr[5]) |-> res_data == (src_a & src_b)); // R3

    AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cc) == 1); // R8

    AST_CC_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(res_we) && !$past(rst)) |->
        cc == ($past(res_data[15]) ? 3'b100 : ($past(res_data) == 16'h0 ? 3'b010 : 3'b001))); // R8

    AST_CC_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        ($past(ld_valid) && !$past(res_we) && !$past(rst)) |->
        cc == ($past(ld_data[15]) ? 3'b100 : ($past(ld_data) == 16'h0 ? 3'b010 : 3'b001))); // R9

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(res_we) && !$past(ld_valid) && !$past(rst)) |-> $stable(cc)); // R10

    AST_CC_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cc == 3'b010); // R10
endmodule

bind alu_nzp_unit opu_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .instr    (instr),
    .src_a    (src_a),
    .src_b    (src_b),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .res_data (res_data),
    .res_we   (res_we),
    .cc       (cc)
);

// File: tb/alu_nzp_unit_tb_top.sv
module alu_nzp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_data = '0;
    logic [2:0]  rd_idx_a, rd_idx_b, res_dst;
    logic [15:0] res_data;
    logic        res_we;
    logic [2:0]  cc;

    int checks = 0;
    int errors = 0;
    logic [2:0]  model_cc = 3'b010;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] pats [8];

    always #2 clk = ~clk;

    alu_nzp_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .ld_valid(ld_valid), .ld_data(ld_data),
        .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .res_data(res_data),
        .res_dst(res_dst), .res_we(res_we), .cc(cc)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] sign_cls(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [15:0] next_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic run_op(input logic ov, input logic [15:0] ins, input logic [15:0] a,
                          input logic [15:0] b, input logic lv, input logic [15:0] ld);
        logic        exp_we;
        logic [15:0] exp_r;
        logic [15:0] opb;
        logic [2:0]  exp_cc;
        string       tag;
        @(negedge clk);
        op_valid = ov; instr = ins; src_a = a; src_b = b; ld_valid = lv; ld_data = ld;
        #1;
        opb = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
        exp_we = 1'b0; exp_r = 16'h0; tag = "R7";
        if (ov) begin
            case (ins[15:12])
                4'b0001: begin exp_we = 1'b1; exp_r = a + opb; tag = ins[5] ? "R2" : "R1_R5"; end
                4'b0101: begin exp_we = 1'b1; exp_r = a & opb; tag = ins[5] ? "R2" : "R3_R5"; end
                4'b1001: begin exp_we = 1'b1; exp_r = ~a;      tag = "R4"; end
                default: ;
            endcase
        end
        chk(res_we == exp_we, "R6 we", {15'h0, res_we}, {15'h0, exp_we});
        if (exp_we) begin
            chk(res_data == exp_r, tag, res_data, exp_r);
            chk(res_dst == ins[11:9], "R6 dst", {13'h0, res_dst}, {13'h0, ins[11:9]});
        end
        chk(rd_idx_a == ins[8:6] && rd_idx_b == ins[2:0], "R6 idx",
            {10'h0, rd_idx_a, rd_idx_b}, {10'h0, ins[8:6], ins[2:0]});
        exp_cc = exp_we ? sign_cls(exp_r) : (lv ? sign_cls(ld) : model_cc);
        @(posedge clk);
        #1;
        chk(cc == exp_cc, exp_we ? "R8" : (lv ? "R9" : "R7_R10 hold"), {13'h0, cc}, {13'h0, exp_cc});
        model_cc = exp_cc;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h7FFF; pats[3] = 16'h8000;
        pats[4] = 16'hFFFF; pats[5] = 16'h1234; pats[6] = 16'hA5C3; pats[7] = 16'h00F0;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(cc == 3'b010, "R10 reset", {13'h0, cc}, 16'h0002);

        // Opcode x operand sweep, register mode with junk in bits 4:3 (R5) or 5:0 for complement (R4)
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    lfsr = next_lfsr(lfsr);
                    run_op(1'b1, {op[3:0], lfsr[2:0], lfsr[5:3], 1'b0, lfsr[7:6], lfsr[10:8]},
                           pats[i], pats[j], 1'b0, 16'h0);
                end
            end
        end

        // All immediates for add and and, against varied first operands and a decoy src_b (R2)
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 8; i++) begin
                for (int im = 0; im < 32; im++) begin
                    lfsr = next_lfsr(lfsr);
                    run_op(1'b1, {(k == 0) ? 4'b0001 : 4'b0101, lfsr[2:0], lfsr[5:3], 1'b1, im[4:0]},
                           pats[i], lfsr, 1'b0, 16'h0);
                end
            end
        end

        // Pseudo-random words over every opcode and field
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] w1, w2;
            lfsr = next_lfsr(lfsr); w1 = lfsr;
            lfsr = next_lfsr(lfsr); w2 = lfsr;
            run_op(1'b1, {w1[15:12], w2[11:0]}, w2 ^ w1, w1, 1'b0, 16'h0);
        end

        // op_valid low with a legal opcode: no write, flags hold (R7, R10)
        run_op(1'b1, 16'h1020, 16'h0005, 16'h0, 1'b0, 16'h0);
        run_op(1'b0, 16'h1020, 16'h8000, 16'h0, 1'b0, 16'h0);
        run_op(1'b0, 16'h9FFF, 16'h0000, 16'h0, 1'b0, 16'h0);

        // Load strobe alone sets flags (R9)
        run_op(1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 16'h8001);
        run_op(1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 16'h0000);
        run_op(1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 16'h7000);
        // Load with an illegal opcode: load wins (R9, R7)
        run_op(1'b1, 16'hF025, 16'h0, 16'h0, 1'b1, 16'hFFFF);
        // Load and operate together: operate wins (R9)
        run_op(1'b1, 16'h5020, 16'hFFFF, 16'h0, 1'b1, 16'h8000);
        run_op(1'b1, 16'h1261, 16'h7FFF, 16'h0, 1'b1, 16'h0000);
        for (int n = 0; n < 200; n++) begin
            lfsr = next_lfsr(lfsr);
            run_op(lfsr[0], {lfsr[15:12], lfsr[11:0] ^ 12'h5A3}, lfsr, ~lfsr, lfsr[1], {lfsr[7:0], lfsr[15:8]});
        end

        // Reset after a positive result returns flags to zero (R10)
        run_op(1'b1, 16'h1021, 16'h0001, 16'h0, 1'b0, 16'h0);
        @(negedge clk); rst = 1'b1; op_valid = 1'b1; instr = 16'h9000; src_a = 16'h0;
        @(posedge clk); #1;
        chk(cc == 3'b010, "R10 reset mid-run", {13'h0, cc}, 16'h0002);
        @(negedge clk); rst = 1'b0; op_valid = 1'b0;
        model_cc = 3'b010;
        run_op(1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule